// File: doc/BRIEF.md
# I2C Register Access Target

This block is an I2C target that lets an external bus host read and write a bank of 8-bit registers. The block samples the SCL and SDA lines with the system clock. From those samples it finds the bus conditions that open and close a transfer, decodes the 7-bit target address and acknowledges each byte it accepts. It drives SDA only through an open-drain enable.

A write transfer starts with the target address and the direction bit clear. The first data byte loads an internal 8-bit register pointer. Every later byte is stored at the pointer, and the pointer then steps by one. A read transfer is a pointer write followed by a repeated START and the target address with the direction bit set. The target then returns registers starting at the pointer and moves to the next register each time the host acknowledges. The read ends when the host leaves the acknowledge bit high.

The register bank sits outside the block. The block gives it one write strobe, a shared register address and a write data bus, and takes back the read data for the addressed register.

Top module: `i2c_reg_target`

## Requirements
- R1: A START (SDA falling while SCL is high) is recognised at any point, including in the middle of a transfer without a STOP before it, and it always restarts decoding with the address byte.
- R2: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released, and after reset SDA is released and no write is issued.
- R3: When the 7 upper bits of the first byte (sent MSB first) equal the configured address, the target holds SDA low during the 9th clock of that byte. Bit 0 of that byte selects the direction: 0 is write, 1 is read.
- R4: When the address does not match, the target gives no acknowledge, writes nothing, leaves all registers unchanged and ignores the bus until the next START or STOP.
- R5: In a write transfer, the first byte after the address is acknowledged and loaded into the register pointer, and it is not stored in any register.
- R6: Each later written byte is acknowledged and stored at the pointer, and the pointer then increments. It wraps from 0xFF to 0x00.
- R7: After a repeated START with the direction bit set, the target acknowledges and then sends the register at the pointer MSB first. The pointer increments for each byte sent.
- R8: A host acknowledge (SDA low on the 9th clock) after a read byte makes the target send the next register. A host NACK (SDA high) ends the data phase, and SDA stays released.
- R9: The target changes its SDA drive only while SCL is low. It drives SDA only for an acknowledge or a 0 data bit.
- R10: The register pointer keeps its value between transfers, so a read with no pointer byte continues where the last transfer stopped.
- R11: Each stored byte gives exactly one single-cycle write strobe, with the register address and data valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| rf_we | output | 1 | Register write strobe, one cycle per stored byte |
| rf_addr | output | 8 | Register address for writes and for the read data |
| rf_wdata | output | 8 | Data to store when rf_we is high |
| rf_rdata | input | 8 | Contents of the register at rf_addr |

## Verification
The hardest case to reach is a pointer that runs across the 0xFF to 0x00 boundary in both directions. The same applies to a read that picks up the pointer left by an earlier transfer, because both depend on a history of earlier transfers and not on one stimulus. The bench reaches them with directed transfers that first place the pointer at 0xFE and then burst across it. It also issues a pointer-less read right after a burst, and a repeated START that cuts into a write. Seeded random write and read bursts, with lengths, pointers and data drawn from $urandom, plus an occasional wrong address, mix these paths further against a model of the register bank and the pointer kept in the bench.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_HACK
    } eng_st_e;

    typedef enum logic [1:0] {
        RK_ADDR,
        RK_PTR,
        RK_DATA
    } rx_kind_e;

    typedef struct packed {
        eng_st_e             st;
        rx_kind_e            kind;
        logic                rd;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic [BYTE_W-1:0]   ptr;
        logic                oe;
        logic                hack;
        logic                we;
        logic [BYTE_W-1:0]   wadr;
        logic [BYTE_W-1:0]   wdat;
    } eng_s;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] cur,
    output logic [LINES-1:0] prev
);

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            logic [STAGES:0] chain_d, chain_q;

            always_comb begin
                chain_d = {chain_q[STAGES-1:0], raw[i]};
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '1;
                end else begin
                    chain_q <= chain_d;
                end
            end

            assign cur[i]  = chain_q[STAGES-1];
            assign prev[i] = chain_q[STAGES];
        end
    endgenerate

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic scl_c,
    input  logic scl_p,
    input  logic sda_c,
    input  logic sda_p,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    always_comb begin
        scl_rise  = scl_c && !scl_p;
        scl_fall  = !scl_c && scl_p;
        bus_start = scl_c && scl_p && sda_p && !sda_c;
        bus_stop  = scl_c && scl_p && !sda_p && sda_c;
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int               ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] TGT_ADDR = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_c,
    input  logic              sda_c,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [BYTE_W-1:0] rf_rdata,
    output logic              sda_oe,
    output logic              rf_we,
    output logic [BYTE_W-1:0] rf_addr,
    output logic [BYTE_W-1:0] rf_wdata
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    eng_s r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        if (bus_stop) begin
            r_d.st  = ST_IDLE;
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
        end else if (bus_start) begin
            r_d.st   = ST_RX;
            r_d.kind = RK_ADDR;
            r_d.cnt  = '0;
            r_d.oe   = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_RX: begin
                    if (scl_rise && r_q.cnt != LAST_BIT) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_c};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == LAST_BIT) begin
                        r_d.cnt = '0;
                        unique case (r_q.kind)
                            RK_ADDR: begin
                                if (r_q.sh[BYTE_W-1:1] == TGT_ADDR) begin
                                    r_d.rd = r_q.sh[0];
                                    r_d.oe = 1'b1;
                                    r_d.st = ST_ACK;
                                end else begin
                                    r_d.st = ST_IDLE;
                                end
                            end
                            RK_PTR: begin
                                r_d.ptr = r_q.sh;
                                r_d.oe  = 1'b1;
                                r_d.st  = ST_ACK;
                            end
                            default: begin
                                r_d.we   = 1'b1;
                                r_d.wadr = r_q.ptr;
                                r_d.wdat = r_q.sh;
                                r_d.ptr  = r_q.ptr + 1'b1;
                                r_d.oe   = 1'b1;
                                r_d.st   = ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.kind == RK_ADDR && r_q.rd) begin
                            r_d.st  = ST_TX;
                            r_d.sh  = rf_rdata;
                            r_d.oe  = !rf_rdata[BYTE_W-1];
                            r_d.ptr = r_q.ptr + 1'b1;
                        end else begin
                            r_d.st   = ST_RX;
                            r_d.oe   = 1'b0;
                            r_d.kind = (r_q.kind == RK_ADDR) ? RK_PTR : RK_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_HACK;
                        end else begin
                            r_d.sh = {r_q.sh[BYTE_W-2:0], 1'b0};
                            r_d.oe = !r_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        r_d.hack = !sda_c;
                    end else if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.hack) begin
                            r_d.st  = ST_TX;
                            r_d.sh  = rf_rdata;
                            r_d.oe  = !rf_rdata[BYTE_W-1];
                            r_d.ptr = r_q.ptr + 1'b1;
                        end else begin
                            r_d.st = ST_IDLE;
                            r_d.oe = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.kind <= RK_ADDR;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe   = r_q.oe;
    assign rf_we    = r_q.we;
    assign rf_addr  = r_q.we ? r_q.wadr : r_q.ptr;
    assign rf_wdata = r_q.wdat;

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.oe) |-> (!$past(scl_c) || $past(bus_start) || $past(bus_stop))); // R9
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (r_q.st == ST_IDLE && !r_q.oe)); // R2
    AST_START_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (r_q.st == ST_RX && r_q.kind == RK_ADDR && r_q.cnt == '0 && !r_q.oe)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> (!r_q.oe && !r_q.we)); // R4
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !bus_start) |=> $stable(r_q.ptr)); // R10
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.we |=> !r_q.we); // R11
    AST_WE_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.we |-> ($past(r_q.st) == ST_RX && $past(r_q.kind) == RK_DATA)); // R6

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int                ADDR_W      = 7,
    parameter logic [ADDR_W-1:0] TGT_ADDR    = 7'h2A,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              rf_we,
    output logic [BYTE_W-1:0] rf_addr,
    output logic [BYTE_W-1:0] rf_wdata,
    input  logic [BYTE_W-1:0] rf_rdata
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_cur, line_prev;
    logic scl_rise, scl_fall, bus_start, bus_stop;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (N_LINES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({scl_i, sda_i}),
        .cur   (line_cur),
        .prev  (line_prev)
    );

    i2c_bus_events i_events (
        .scl_c     (line_cur[1]),
        .scl_p     (line_prev[1]),
        .sda_c     (line_cur[0]),
        .sda_p     (line_prev[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_tgt_engine #(
        .ADDR_W   (ADDR_W),
        .TGT_ADDR (TGT_ADDR)
    ) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_c     (line_cur[1]),
        .sda_c     (line_cur[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .rf_rdata  (rf_rdata),
        .sda_oe    (sda_oe),
        .rf_we     (rf_we),
        .rf_addr   (rf_addr),
        .rf_wdata  (rf_wdata)
    );

endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;

    localparam int         QT  = 6;
    localparam logic [6:0] DEV = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe, rf_we;
    logic [7:0] rf_addr, rf_wdata, rf_rdata;
    wire  sda_line = sda_h & ~sda_oe;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr = 8'h00;
    logic [7:0] wbuf [8];
    int total = 0, bad = 0, we_cnt = 0, exp_we = 0, drv_viol = 0;
    logic oe_prev = 1'b0;
    bit done = 1'b0;
    int wd = 0;

    always #2.5 clk = ~clk;

    i2c_reg_target i_i2c_reg_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_h),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .rf_we    (rf_we),
        .rf_addr  (rf_addr),
        .rf_wdata (rf_wdata),
        .rf_rdata (rf_rdata)
    );

    assign rf_rdata = mem[rf_addr];

    always @(posedge clk) begin
        if (rf_we) begin
            mem[rf_addr] <= rf_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    // R9 monitor: drive changes while the raw clock line is high
    always @(negedge clk) begin
        if (rst_n && (sda_oe != oe_prev) && scl_h) drv_viol++;
        oe_prev <= sda_oe;
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd == 190000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=done", wd);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        repeat (QT) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; tick();
        scl_h = 1'b1; tick();
        sda_h = 1'b0; tick();
        scl_h = 1'b0; tick();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick();
        scl_h = 1'b1; tick();
        sda_h = 1'b1; tick();
    endtask

    task automatic put_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; tick();
            scl_h = 1'b1; tick();
            scl_h = 1'b0;
        end
        tick();
        sda_h = 1'b1; tick();
        scl_h = 1'b1; tick();
        ack = !sda_line;
        scl_h = 1'b0; tick();
    endtask

    task automatic get_byte(input bit give_ack, output logic [7:0] d);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick();
            scl_h = 1'b1; tick();
            d[i] = sda_line;
            scl_h = 1'b0;
        end
        tick();
        sda_h = !give_ack; tick();
        scl_h = 1'b1; tick();
        scl_h = 1'b0; tick();
        sda_h = 1'b1;
    endtask

    function automatic logic [7:0] seed_val(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    // write burst of n bytes from wbuf after pointer p, to address a
    task automatic xfer_write(input logic [6:0] a, input logic [7:0] p, input int n);
        bit ack;
        bus_start();
        put_byte({a, 1'b0}, ack);
        if (a == DEV) begin
            chk(ack, "R3 address ack", ack, 1);
            put_byte(p, ack);
            chk(ack, "R5 pointer ack", ack, 1);
            exp_ptr = p;
            for (int i = 0; i < n; i++) begin
                put_byte(wbuf[i], ack);
                chk(ack, "R6 data ack", ack, 1);
                exp_mem[exp_ptr] = wbuf[i];
                exp_ptr = exp_ptr + 8'd1;
                exp_we++;
            end
        end else begin
            chk(!ack, "R4 no ack on mismatch", ack, 0);
            put_byte(p, ack);
            chk(!ack, "R4 bus ignored", ack, 0);
        end
        bus_stop();
    endtask

    task automatic read_burst(input int n);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            get_byte(i < n - 1, d);
            chk(d == exp_mem[exp_ptr], "R7 R8 read data", d, exp_mem[exp_ptr]);
            exp_ptr = exp_ptr + 8'd1;
        end
        chk(!sda_oe, "R8 released after NACK", sda_oe, 0);
        bus_stop();
    endtask

    task automatic xfer_read(input bit set_ptr, input logic [7:0] p, input int n);
        bit ack;
        bus_start();
        if (set_ptr) begin
            put_byte({DEV, 1'b0}, ack);
            chk(ack, "R3 address ack", ack, 1);
            put_byte(p, ack);
            chk(ack, "R5 pointer ack", ack, 1);
            exp_ptr = p;
            bus_start();
        end
        put_byte({DEV, 1'b1}, ack);
        chk(ack, "R7 read address ack", ack, 1);
        read_burst(n);
    endtask

    initial begin
        bit ack;
        int mism;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) begin
            mem[i] = seed_val(i);
            exp_mem[i] = seed_val(i);
        end
        repeat (10) @(negedge clk);
        chk(!sda_oe && !rf_we, "R2 reset state", {sda_oe, rf_we}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(!sda_oe, "R2 idle released", sda_oe, 0);

        // directed: burst write, burst read back
        wbuf[0] = 8'h00; wbuf[1] = 8'hFF; wbuf[2] = 8'hA5;
        xfer_write(DEV, 8'h10, 3);
        chk(exp_ptr == 8'h13, "R6 pointer model", exp_ptr, 8'h13);
        xfer_read(1'b1, 8'h10, 3);
        // R10: read with no pointer byte continues at 0x13
        xfer_read(1'b0, 8'h00, 2);
        // R6 wrap on write and read
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        xfer_write(DEV, 8'hFE, 3);
        chk(exp_ptr == 8'h01, "R6 wrap pointer", exp_ptr, 8'h01);
        xfer_read(1'b1, 8'hFE, 4);
        // R4: wrong address, nothing written
        wbuf[0] = 8'hEE; wbuf[1] = 8'hDD;
        xfer_write(7'h2B, 8'h40, 2);
        xfer_read(1'b1, 8'h40, 1);
        chk(we_cnt == exp_we, "R4 no strobe on mismatch", we_cnt, exp_we);
        // R1: repeated START cutting into a write
        bus_start();
        put_byte({DEV, 1'b0}, ack);
        put_byte(8'h20, ack);
        put_byte(8'hC3, ack);
        chk(ack, "R6 data ack", ack, 1);
        exp_mem[8'h20] = 8'hC3; exp_ptr = 8'h21; exp_we++;
        bus_start();
        put_byte({DEV, 1'b1}, ack);
        chk(ack, "R1 repeated START read ack", ack, 1);
        read_burst(2);
        // R1: mismatch then repeated START with a matching read
        bus_start();
        put_byte({7'h11, 1'b0}, ack);
        chk(!ack, "R4 no ack on mismatch", ack, 0);
        bus_start();
        put_byte({DEV, 1'b1}, ack);
        chk(ack, "R1 decode restarts", ack, 1);
        read_burst(1);

        // seeded random transfers
        for (int t = 0; t < 30; t++) begin
            int op = int'($urandom_range(0, 9));
            int n = int'($urandom_range(1, 4));
            logic [7:0] p = 8'($urandom_range(0, 255));
            if (op < 4) begin
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom_range(0, 255));
                xfer_write(DEV, p, n);
            end else if (op < 7) begin
                xfer_read(1'b1, p, n);
            end else if (op < 9) begin
                xfer_read(1'b0, 8'h00, n);
            end else begin
                xfer_write(7'h55, p, 1);
            end
        end

        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
        chk(mism == 0, "R6 register bank contents", mism, 0);
        chk(we_cnt == exp_we, "R11 write strobe count", we_cnt, exp_we);
        chk(drv_viol == 0, "R9 drive change with SCL high", drv_viol, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule